// File: doc/BRIEF.md
# Transmit Descriptor Engine

This block owns four transmit descriptor slots. Each slot holds a buffer start address and a status word written by the host through a small register port. When the host writes a slot's status word with a frame length, the block marks the slot pending. Once its turn comes, the block reads the frame from memory in aligned 32-bit words and places the bytes in an internal byte FIFO. It then streams them out one byte per handshake on a byte-stream port.

Output of a frame starts when the FIFO holds enough bytes to meet the slot's early-start threshold, when the whole frame is buffered, or when the FIFO is nearly full. Short frames are sent as given, with no padding; the frame check sequence is added downstream. The block serves slots strictly in rotation. If the memory reads fall behind the output, the frame is aborted as an underrun. At the end of each frame the block records the outcome in the slot's status word and sets a success or error bit in an interrupt status register. The host clears those bits by writing ones.

Top module: `txd_engine`

## Requirements
- R1: After reset, every status word, address word and the interrupt status read as zero, and `irq_o`, `mem_req_o` and `tx_valid_o` are low.
- R2: Slot n's address word is at register offset 0x20+4n and reads back as written. Slot n's status word is at offset 0x10+4n, with the length in bits 12:0 and the early-start threshold (in 32-byte units) in bits 21:16.
- R3: A status write while `tx_en_i` is low has no effect: the status word keeps its value, no memory read is issued and no byte is sent.
- R4: A status write with `tx_en_i` high clears the slot's done (bit 15), underrun (bit 14) and fetch-complete (bit 13) flags, and the cleared word reads back at once.
- R5: Frame byte i is taken from the word at byte address base+4*floor(i/4), lane i mod 4 (lane k in data bits 8k+7:8k). Memory addresses are word aligned. `tx_last_o` marks exactly the final byte.
- R6: The first byte of a frame is not offered before min(32*threshold, length) bytes of it have been read from memory. The threshold counts only up to the FIFO capacity.
- R7: Slots are served strictly in the order 0, 1, 2, 3, 0, whatever order the host writes them in.
- R8: On a complete frame, status bits 15 and 13 are set, bit 14 is clear, interrupt status bit 2 is set and `irq_o` goes high.
- R9: When the FIFO runs empty with `tx_ready_i` high before the frame's last byte, the block pulses `tx_abort_o`, stops sending, sets status bit 14 with bits 15 and 13 clear, and sets interrupt status bit 3. The next slot is then served normally.
- R10: The interrupt status register is at offset 0x3C. Writing a one to bit 2 or bit 3 clears that bit, and `irq_o` is the OR of the two bits.
- R11: A frame of length zero completes at once with bits 15 and 13 set and sends no byte.
- R12: No padding is added: a frame shorter than 60 bytes is sent with exactly its programmed length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tx_en_i | input | 1 | Transmit enable; gates status writes |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte offset |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational on address) |
| irq_o | output | 1 | Interrupt, OR of the two event bits |
| mem_req_o | output | 1 | Word read request, held until response |
| mem_addr_o | output | 32 | Word-aligned byte address of the read |
| mem_rvalid_i | input | 1 | Read response valid |
| mem_rdata_i | input | 32 | Read response data, little-endian lanes |
| tx_valid_o | output | 1 | Output byte valid |
| tx_data_o | output | 8 | Output byte |
| tx_last_o | output | 1 | Final byte of frame |
| tx_abort_o | output | 1 | One-cycle pulse: frame aborted on underrun |
| tx_ready_i | input | 1 | Sink accepts a byte |

## Verification
A corrupted slot pointer shows up as bytes from the wrong buffer on the first byte of the next frame, and as a broken service order once slots are written out of order. A miscounted fetch or send counter shows at the end of the first affected frame, as a missing, early or late `tx_last_o` or as a wrong byte lane. A wrong start or underrun decision shows within the frame where it happens: the first byte appears before the threshold is met, or an abort occurs without a real starvation. Status and interrupt bits are read back after each frame, so a wrong completion flag shows on the very next poll.

// File: rtl/txd_pkg.sv
package txd_pkg;
  localparam int NSLOT  = 4;
  localparam int SLOT_W = 2;
  localparam int LEN_W  = 13;
  localparam int THR_W  = 6;
  localparam int OWN_BIT = 13;
  localparam int UND_BIT = 14;
  localparam int OK_BIT  = 15;
  localparam int THR_LSB = 16;
  localparam logic [7:0] STAT_BASE = 8'h10;
  localparam logic [7:0] ADDR_BASE = 8'h20;
  localparam logic [7:0] INT_ADDR  = 8'h3C;
  localparam int INT_OK  = 2;
  localparam int INT_ERR = 3;

  typedef struct packed {
    logic [31:0]      addr;
    logic [THR_W-1:0] thr;
    logic [LEN_W-1:0] len;
  } slot_cfg_t;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DRAIN} eng_st_t;
endpackage

// File: rtl/txd_regs.sv
module txd_regs
  import txd_pkg::*;
(
  input  logic                         clk_i,
  input  logic                         rst_ni,
  input  logic                         en_i,
  input  logic                         we_i,
  input  logic [7:0]                   addr_i,
  input  logic [31:0]                  wdata_i,
  output logic [31:0]                  rdata_o,
  output slot_cfg_t [NSLOT-1:0]        cfg_o,
  output logic [NSLOT-1:0]             pend_o,
  input  logic [SLOT_W-1:0]            cur_i,
  input  logic                         busy_i,
  input  logic                         take_i,
  input  logic                         fin_i,
  input  logic                         fin_ok_i,
  input  logic                         fin_own_i,
  output logic                         irq_o
);
  logic [NSLOT-1:0][31:0] stat_w;
  logic [1:0]             int_q;

  for (genvar n = 0; n < NSLOT; n++) begin : g_slot
    logic [LEN_W-1:0] len_q;
    logic [THR_W-1:0] thr_q;
    logic [31:0]      addr_q;
    logic             own_q, ok_q, und_q, pend_q;
    logic             is_cur, stat_hit, addr_hit;

    assign is_cur   = cur_i == SLOT_W'(n);
    // the slot the engine holds or is taking is not rewritable
    assign stat_hit = we_i && en_i && (addr_i == STAT_BASE + 8'(4*n)) && !(is_cur && (busy_i || take_i));
    assign addr_hit = we_i && (addr_i == ADDR_BASE + 8'(4*n));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        len_q <= '0; thr_q <= '0; addr_q <= '0;
        own_q <= 1'b0; ok_q <= 1'b0; und_q <= 1'b0; pend_q <= 1'b0;
      end else begin
        if (addr_hit) addr_q <= wdata_i;
        if (stat_hit) begin
          len_q  <= wdata_i[LEN_W-1:0];
          thr_q  <= wdata_i[THR_LSB +: THR_W];
          own_q  <= 1'b0; ok_q <= 1'b0; und_q <= 1'b0;
          pend_q <= 1'b1;
        end else begin
          if (take_i && is_cur) pend_q <= 1'b0;
          if (fin_i && is_cur) begin
            own_q <= fin_own_i;
            ok_q  <= fin_ok_i;
            und_q <= !fin_ok_i;
          end
        end
      end
    end

    assign stat_w[n] = {{(32-THR_LSB-THR_W){1'b0}}, thr_q, ok_q, und_q, own_q, len_q};
    assign cfg_o[n]  = '{addr: addr_q, thr: thr_q, len: len_q};
    assign pend_o[n] = pend_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) int_q <= '0;
    else begin
      logic [1:0] clr, set;
      clr = (we_i && addr_i == INT_ADDR) ? {wdata_i[INT_ERR], wdata_i[INT_OK]} : 2'b00;
      set = {fin_i && !fin_ok_i, fin_i && fin_ok_i};
      int_q <= (int_q & ~clr) | set;
    end
  end

  always_comb begin
    rdata_o = '0;
    for (int n = 0; n < NSLOT; n++) begin
      if (addr_i == STAT_BASE + 8'(4*n)) rdata_o = stat_w[n];
      if (addr_i == ADDR_BASE + 8'(4*n)) rdata_o = cfg_o[n].addr;
    end
    if (addr_i == INT_ADDR) rdata_o = {28'd0, int_q, 2'b00};
  end

  assign irq_o = |int_q;
endmodule

// File: rtl/txd_fifo.sv
module txd_fifo #(
  parameter int DEPTH = 64,
  localparam int PW    = $clog2(DEPTH),
  localparam int CNT_W = PW + 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             flush_i,
  input  logic [2:0]       push_n_i,
  input  logic [31:0]      push_data_i,
  input  logic             pop_i,
  output logic [7:0]       data_o,
  output logic [CNT_W-1:0] count_o,
  output logic             empty_o
);
  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] wp_q, rp_q;

  always_ff @(posedge clk_i) begin
    for (int k = 0; k < 4; k++)
      if (!flush_i && 3'(k) < push_n_i) mem[wp_q + PW'(k)] <= push_data_i[8*k +: 8];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q <= '0; rp_q <= '0; count_o <= '0;
    end else if (flush_i) begin
      wp_q <= '0; rp_q <= '0; count_o <= '0;
    end else begin
      wp_q    <= wp_q + PW'(push_n_i);
      rp_q    <= rp_q + PW'(pop_i);
      count_o <= count_o + CNT_W'(push_n_i) - CNT_W'(pop_i);
    end
  end

  assign data_o  = mem[rp_q];
  assign empty_o = count_o == '0;
endmodule

// File: rtl/txd_ctrl.sv
module txd_ctrl
  import txd_pkg::*;
#(
  parameter int DEPTH = 64,
  localparam int CNT_W = $clog2(DEPTH) + 1
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic [NSLOT-1:0]      pend_i,
  input  slot_cfg_t [NSLOT-1:0] cfg_i,
  output logic [SLOT_W-1:0]     cur_o,
  output logic                  take_o,
  output logic                  busy_o,
  output logic                  fin_o,
  output logic                  fin_ok_o,
  output logic                  fin_own_o,
  output logic                  mem_req_o,
  output logic [31:0]           mem_addr_o,
  input  logic                  mem_rvalid_i,
  input  logic [31:0]           mem_rdata_i,
  output logic [2:0]            push_n_o,
  output logic [31:0]           push_data_o,
  output logic                  flush_o,
  output logic                  pop_o,
  input  logic [CNT_W-1:0]      count_i,
  input  logic                  empty_i,
  input  logic                  tx_ready_i,
  output logic                  tx_valid_o,
  output logic                  tx_last_o,
  output logic                  tx_abort_o
);
  eng_st_t          st_q;
  logic [SLOT_W-1:0] cur_q;
  logic [LEN_W-1:0] len_q, f_cnt_q, s_cnt_q, remain;
  logic [THR_W-1:0] thr_q;
  logic [31:0]      base_q;
  logic             outst_q, started_q;
  logic             fetch_done, room, issue, start_ok, live, underrun, rsp;
  logic [2:0]       n_word;

  assign fetch_done = f_cnt_q == len_q;
  assign remain     = len_q - f_cnt_q;
  assign n_word     = (remain >= LEN_W'(4)) ? 3'd4 : remain[2:0];
  assign room       = count_i <= CNT_W'(DEPTH - 4);
  assign issue      = st_q == S_RUN && !outst_q && !fetch_done && room;
  assign rsp        = outst_q && mem_rvalid_i;

  // start once threshold met, frame fully buffered, or FIFO can take no more
  assign start_ok = (count_i != '0 && 16'(count_i) >= {5'd0, thr_q, 5'd0}) || fetch_done || !room;
  assign live     = st_q == S_RUN && (started_q || start_ok);
  assign underrun = st_q == S_RUN && started_q && empty_i && tx_ready_i;

  assign tx_valid_o  = live && !empty_i;
  assign pop_o       = tx_valid_o && tx_ready_i;
  assign tx_last_o   = tx_valid_o && (s_cnt_q == len_q - LEN_W'(1));
  assign tx_abort_o  = underrun;
  assign mem_req_o   = outst_q;
  assign mem_addr_o  = {base_q[31:2], 2'b00} + 32'(f_cnt_q);
  assign push_n_o    = (st_q == S_RUN && rsp) ? n_word : 3'd0;
  assign push_data_o = mem_rdata_i;
  assign flush_o     = st_q == S_DRAIN;
  assign take_o      = st_q == S_IDLE && pend_i[cur_q];
  assign busy_o      = st_q != S_IDLE;
  assign cur_o       = cur_q;

  always_comb begin
    fin_o = 1'b0; fin_ok_o = 1'b0; fin_own_o = 1'b0;
    if (take_o && cfg_i[cur_q].len == '0) begin
      fin_o = 1'b1; fin_ok_o = 1'b1; fin_own_o = 1'b1;
    end else if (pop_o && tx_last_o) begin
      fin_o = 1'b1; fin_ok_o = 1'b1; fin_own_o = fetch_done;
    end else if (st_q == S_DRAIN && !outst_q) begin
      fin_o = 1'b1; fin_own_o = fetch_done;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q <= S_IDLE; cur_q <= '0; len_q <= '0; thr_q <= '0; base_q <= '0;
      f_cnt_q <= '0; s_cnt_q <= '0; outst_q <= 1'b0; started_q <= 1'b0;
    end else begin
      unique case (st_q)
        S_IDLE: if (take_o) begin
          len_q <= cfg_i[cur_q].len; thr_q <= cfg_i[cur_q].thr; base_q <= cfg_i[cur_q].addr;
          f_cnt_q <= '0; s_cnt_q <= '0; outst_q <= 1'b0; started_q <= 1'b0;
          if (cfg_i[cur_q].len == '0) cur_q <= cur_q + 1'b1;
          else st_q <= S_RUN;
        end
        S_RUN: begin
          if (issue) outst_q <= 1'b1;
          if (rsp) begin
            outst_q <= 1'b0;
            f_cnt_q <= f_cnt_q + LEN_W'(n_word);
          end
          if (pop_o) begin
            s_cnt_q <= s_cnt_q + 1'b1;
            started_q <= 1'b1;
          end
          if (pop_o && tx_last_o) begin
            st_q <= S_IDLE; cur_q <= cur_q + 1'b1;
          end else if (underrun) st_q <= S_DRAIN;
        end
        S_DRAIN: begin
          if (rsp) outst_q <= 1'b0;
          if (!outst_q) begin
            st_q <= S_IDLE; cur_q <= cur_q + 1'b1;
          end
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/txd_engine.sv
module txd_engine
  import txd_pkg::*;
#(
  parameter int FIFO_DEPTH = 64
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        tx_en_i,
  input  logic        reg_we_i,
  input  logic [7:0]  reg_addr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        irq_o,
  output logic        mem_req_o,
  output logic [31:0] mem_addr_o,
  input  logic        mem_rvalid_i,
  input  logic [31:0] mem_rdata_i,
  output logic        tx_valid_o,
  output logic [7:0]  tx_data_o,
  output logic        tx_last_o,
  output logic        tx_abort_o,
  input  logic        tx_ready_i
);
  localparam int CNT_W = $clog2(FIFO_DEPTH) + 1;

  slot_cfg_t [NSLOT-1:0] cfg;
  logic [NSLOT-1:0]      pend;
  logic [SLOT_W-1:0]     cur;
  logic                  take, busy, fin, fin_ok, fin_own, flush, pop, empty;
  logic [2:0]            push_n;
  logic [31:0]           push_data;
  logic [CNT_W-1:0]      count;

  txd_regs u_regs (
    .clk_i, .rst_ni, .en_i(tx_en_i), .we_i(reg_we_i), .addr_i(reg_addr_i),
    .wdata_i(reg_wdata_i), .rdata_o(reg_rdata_o), .cfg_o(cfg), .pend_o(pend),
    .cur_i(cur), .busy_i(busy), .take_i(take), .fin_i(fin), .fin_ok_i(fin_ok),
    .fin_own_i(fin_own), .irq_o
  );

  txd_ctrl #(.DEPTH(FIFO_DEPTH)) u_ctrl (
    .clk_i, .rst_ni, .pend_i(pend), .cfg_i(cfg), .cur_o(cur), .take_o(take),
    .busy_o(busy), .fin_o(fin), .fin_ok_o(fin_ok), .fin_own_o(fin_own),
    .mem_req_o, .mem_addr_o, .mem_rvalid_i, .mem_rdata_i,
    .push_n_o(push_n), .push_data_o(push_data), .flush_o(flush), .pop_o(pop),
    .count_i(count), .empty_i(empty), .tx_ready_i, .tx_valid_o, .tx_last_o, .tx_abort_o
  );

  txd_fifo #(.DEPTH(FIFO_DEPTH)) u_fifo (
    .clk_i, .rst_ni, .flush_i(flush), .push_n_i(push_n), .push_data_i(push_data),
    .pop_i(pop), .data_o(tx_data_o), .count_o(count), .empty_o(empty)
  );
endmodule

// File: rtl/txd_engine_chk.sv
module txd_engine_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        mem_req_o,
  input logic [31:0] mem_addr_o,
  input logic        mem_rvalid_i,
  input logic        tx_valid_o,
  input logic [7:0]  tx_data_o,
  input logic        tx_last_o,
  input logic        tx_abort_o,
  input logic        tx_ready_i
);
  p_req_align_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> mem_addr_o[1:0] == 2'b00);

  p_req_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o && !mem_rvalid_i |=> mem_req_o && $stable(mem_addr_o));

  p_data_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_valid_o && !tx_ready_i |=> tx_valid_o && $stable(tx_data_o));

  p_last_valid_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_last_o |-> tx_valid_o);

  p_abort_idle_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_abort_o |-> !tx_valid_o && tx_ready_i);

  p_abort_once_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_abort_o |=> !tx_abort_o);
endmodule

bind txd_engine txd_engine_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
  .mem_rvalid_i(mem_rvalid_i), .tx_valid_o(tx_valid_o), .tx_data_o(tx_data_o),
  .tx_last_o(tx_last_o), .tx_abort_o(tx_abort_o), .tx_ready_i(tx_ready_i)
);

// File: tb/txd_engine_tb.sv
module txd_engine_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk_i = 1'b0, rst_ni = 1'b0, tx_en_i = 1'b0;
  logic        reg_we_i = 1'b0;
  logic [7:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0, reg_rdata_o;
  logic        irq_o, mem_req_o, mem_rvalid_i = 1'b0;
  logic [31:0] mem_addr_o, mem_rdata_i = '0;
  logic        tx_valid_o, tx_last_o, tx_abort_o, tx_ready_i = 1'b0;
  logic [7:0]  tx_data_o;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  txd_engine u_dut (.*);

  int total = 0, bad = 0;
  bit finished = 0;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] mbyte(input logic [31:0] a);
    return 8'((a * 32'd13) ^ (a >> 8) ^ 32'h5A);
  endfunction

  function automatic logic [31:0] st_word(input int len, input int thr, input bit ok, input bit und, input bit own);
    return {10'd0, 6'(thr), ok, und, own, 13'(len)};
  endfunction

  // memory model
  int  mem_lat = 0;
  int  resp_total = 0, req_cycles = 0;
  bit  m_busy = 0;
  int  m_cnt = 0;
  logic [31:0] m_addr;
  int  ready_pct = 100;

  always @(posedge clk_i) begin
    tx_ready_i <= ($urandom % 100) < ready_pct;
    if (mem_req_o) req_cycles++;
    if (mem_rvalid_i) begin
      mem_rvalid_i <= 1'b0; m_busy = 0; resp_total++;
    end else if (m_busy) begin
      if (m_cnt == 0) begin
        mem_rvalid_i <= 1'b1;
        mem_rdata_i <= {mbyte(m_addr+3), mbyte(m_addr+2), mbyte(m_addr+1), mbyte(m_addr)};
      end else m_cnt--;
    end else if (mem_req_o) begin
      m_busy = 1; m_addr = mem_addr_o;
      if (mem_lat == 0) begin
        mem_rvalid_i <= 1'b1;
        mem_rdata_i <= {mbyte(m_addr+3), mbyte(m_addr+2), mbyte(m_addr+1), mbyte(m_addr)};
      end else m_cnt = mem_lat - 1;
    end
  end

  // stream monitor
  logic [31:0] exp_base [4];
  int exp_len [4];
  int exp_cur = 0, idx = 0, fr_bad = 0, byte_bad = 0, resp_base = 0, first_fetch = 0;
  int last_cnt = 0, last_bad = 0, last_first = 0, log_n = 0;
  bit last_abort = 0;
  int log_slot [64];

  task automatic close_frame(input bit ab);
    last_cnt = idx; last_bad = fr_bad; last_abort = ab; last_first = first_fetch;
    log_slot[log_n] = exp_cur; log_n++;
    exp_cur = (exp_cur + 1) % 4;
    idx = 0; fr_bad = 0; resp_base = resp_total;
  endtask

  always @(negedge clk_i) if (rst_ni) begin
    if (tx_valid_o && tx_ready_i) begin
      if (idx == 0) first_fetch = 4 * (resp_total - resp_base);
      if (tx_data_o !== mbyte(exp_base[exp_cur] + 32'(idx))) begin fr_bad++; byte_bad++; end
      if (tx_last_o !== (idx == exp_len[exp_cur] - 1)) begin fr_bad++; byte_bad++; end
      idx++;
      if (tx_last_o) close_frame(0);
    end else if (tx_abort_o) close_frame(1);
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk_i); reg_we_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i); reg_we_i = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk_i); reg_addr_i = a; #1 d = reg_rdata_o;
  endtask

  task automatic wait_done(input int slot, output logic [31:0] st);
    for (int i = 0; i < 20000; i++) begin
      rd(8'h10 + 8'(4*slot), st);
      if (st[15] || st[14]) return;
    end
    chk("R8 completion timeout", 32'd0, 32'd1);
  endtask

  task automatic arm(input int slot, input logic [31:0] base, input int len, input int thr);
    exp_base[slot] = base; exp_len[slot] = len;
    wr(8'h20 + 8'(4*slot), base);
    wr(8'h10 + 8'(4*slot), st_word(len, thr, 0, 0, 0));
  endtask

  task automatic send(input logic [31:0] base, input int len, input int thr, output logic [31:0] st);
    int s;
    s = exp_cur;
    arm(s, base, len, thr);
    wait_done(s, st);
  endtask

  initial begin
    logic [31:0] d, st;
    int s0, n0, bb0;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk_i);
    // R1 reset state
    chk("R1 irq/req/valid low", {29'd0, irq_o, mem_req_o, tx_valid_o}, 32'd0);
    rst_ni = 1'b1;
    rd(8'h10, d); chk("R1 status0 zero", d, 32'd0);
    rd(8'h2C, d); chk("R1 addr3 zero", d, 32'd0);
    rd(8'h3C, d); chk("R1 int status zero", d, 32'd0);

    // R2 register map
    for (int n = 0; n < 4; n++) begin
      logic [31:0] v;
      v = 32'h1000_0000 + 32'(n) * 32'h0101_0404;
      wr(8'h20 + 8'(4*n), v);
      rd(8'h20 + 8'(4*n), d); chk($sformatf("R2 addr slot %0d", n), d, v);
    end

    // R3 ignored when disabled
    tx_en_i = 1'b0;
    wr(8'h10, st_word(80, 1, 0, 0, 0));
    repeat (40) @(negedge clk_i);
    rd(8'h10, d); chk("R3 status unchanged", d, 32'd0);
    chk("R3 no traffic", 32'(req_cycles + log_n), 32'd0);
    tx_en_i = 1'b1;

    // R5 R8 basic frame on slot 0
    ready_pct = 100; mem_lat = 0;
    send(32'h0000_1000, 60, 0, st);
    chk("R8 status ok", st, st_word(60, 0, 1, 0, 1));
    chk("R5 frame bytes", 32'(last_bad), 32'd0);
    chk("R5 frame length", 32'(last_cnt), 32'd60);
    rd(8'h3C, d); chk("R8 int ok bit2", d, 32'h4);
    chk("R8 irq high", {31'd0, irq_o}, 32'd1);
    wr(8'h3C, 32'h4);
    rd(8'h3C, d); chk("R10 int cleared", d, 32'd0);
    chk("R10 irq low", {31'd0, irq_o}, 32'd0);

    // R12 short frame, R2 field readback
    send(32'h0000_2004, 5, 3, st);
    chk("R2 status fields", st, st_word(5, 3, 1, 0, 1));
    chk("R12 no padding", 32'(last_cnt), 32'd5);
    chk("R12 short bytes", 32'(last_bad), 32'd0);

    // R6 threshold of 64 bytes
    mem_lat = 1; ready_pct = 60;
    send(32'h0000_3000, 150, 2, st);
    chk("R6 first byte after 64 fetched", 32'(last_first >= 64), 32'd1);
    chk("R6 frame ok", {last_bad == 0, last_cnt == 150}, 32'd3);
    mem_lat = 0; ready_pct = 100;
    send(32'h0000_3800, 70, 1, st);
    chk("R6 slot3 frame", st, st_word(70, 1, 1, 0, 1));

    // R4 rewrite clears flags (slot 0 is next)
    exp_base[0] = 32'h0000_4000; exp_len[0] = 64;
    wr(8'h20, 32'h0000_4000);
    wr(8'h10, st_word(64, 1, 1, 1, 1));
    rd(8'h10, d); chk("R4 flags cleared", d, st_word(64, 1, 0, 0, 0));
    wait_done(0, st);
    chk("R4 rewritten frame ok", st, st_word(64, 1, 1, 0, 1));

    // R11 zero length on slot 1
    n0 = log_n;
    exp_len[1] = 0;
    wr(8'h10 + 8'd4, st_word(0, 0, 0, 0, 0));
    wait_done(1, st);
    chk("R11 zero length status", st, st_word(0, 0, 1, 0, 1));
    chk("R11 no bytes", 32'(log_n - n0), 32'd0);
    exp_cur = 2;
    wr(8'h3C, 32'hC);

    // R9 underrun on slot 2
    mem_lat = 20;
    send(32'h0000_5000, 120, 1, st);
    chk("R9 underrun status", st, st_word(120, 1, 0, 1, 0));
    chk("R9 abort seen", {31'd0, last_abort}, 32'd1);
    chk("R9 frame cut short", 32'(last_cnt < 120), 32'd1);
    rd(8'h3C, d); chk("R9 int err bit3", d, 32'h8);
    wr(8'h3C, 32'h8);
    mem_lat = 0;
    send(32'h0000_5800, 90, 0, st);
    chk("R9 next slot ok", st, st_word(90, 0, 1, 0, 1));
    chk("R9 next slot bytes", {last_bad == 0, last_cnt == 90}, 32'd3);

    // R7 strict order regardless of write order
    s0 = exp_cur; n0 = log_n; bb0 = byte_bad;
    arm((s0 + 2) % 4, 32'h0000_6000, 40, 0);
    repeat (30) @(negedge clk_i);
    chk("R7 later slot waits", 32'(log_n - n0), 32'd0);
    arm((s0 + 1) % 4, 32'h0000_6400, 44, 0);
    repeat (30) @(negedge clk_i);
    chk("R7 still waiting", 32'(log_n - n0), 32'd0);
    arm(s0, 32'h0000_6800, 48, 0);
    wait_done((s0 + 2) % 4, st);
    chk("R7 order", {8'(log_slot[n0]), 8'(log_slot[n0+1]), 8'(log_slot[n0+2])},
        {8'(s0), 8'((s0 + 1) % 4), 8'((s0 + 2) % 4)});
    chk("R7 order data", 32'(byte_bad - bb0), 32'd0);

    // constrained random frames
    for (int k = 0; k < 12; k++) begin
      int len, thr;
      logic [31:0] base;
      len = 1 + int'($urandom % 200);
      thr = int'($urandom % 4);
      base = ($urandom % 32'h10000) & 32'hFFFC;
      ready_pct = 50 + int'($urandom % 51);
      send(base, len, thr, st);
      chk($sformatf("R8 random %0d status", k), st, st_word(len, thr, 1, 0, 1));
      chk($sformatf("R5 random %0d bytes", k), {last_bad == 0, last_cnt == len}, 32'd3);
    end

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog R8 act=hung exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule